// File: doc/BRIEF.md
# HDLC Transmit Pool Controller

This block sits between a host and a bit-level HDLC serializer. It holds two byte banks of equal depth. At any moment one bank belongs to the host and the other feeds the serializer. The host fills its bank and then commits it with one of two commands. A continue command hands over a full bank in the middle of a frame. An end command closes the frame and may carry any length from one byte up to the bank depth. Once the serializer-side bank is empty and a committed bank is waiting, the two banks trade roles. The host then sees its pool-ready flag again and can fill the next block.

Bytes go to the serializer over a valid/ready handshake. The final byte of a frame carries a last flag. If the serializer asks for a byte in the middle of a frame and nothing is available, the block signals an underrun and requests an abort sequence, and the host's partly filled bank is thrown away. A registered all-sent flag reports that both banks are empty, no frame is open and the serializer says the line is idle. Flag insertion, bit stuffing and the frame check sequence are handled by the serializer.

Top module: `hdlc_tx_pool`

## Requirements
- R1: Directly after reset, poolReady is 1 and serValid, serAbort, underrunEvt and allSent are 0. With lineIdle at 1, allSent becomes 1 after the first clock edge.
- R2: Each cycle with hostWrEn high stores hostWrData at the next free position of the host bank. A write is ignored once the bank already holds DEPTH bytes, so the stored block keeps its first DEPTH bytes.
- R3: cmdSend is accepted only when the host bank holds exactly DEPTH bytes. cmdEnd is accepted with 1 to DEPTH bytes. A command with an empty bank, or cmdSend with a partly filled bank, is ignored and poolReady stays 1.
- R4: poolReady falls in the cycle after a command is accepted. The banks trade roles in the first cycle in which a committed bank waits and the serializer bank is empty, and poolReady is 1 again in the cycle after that trade.
- R5: Bytes reach serData in the order the host wrote them, across banks. While serValid is 1 and serReady is 0, serValid stays 1 and serData stays unchanged.
- R6: serLast is 1 only with the final byte of a block committed by cmdEnd. It is never 1 with the final byte of a block committed by cmdSend.
- R7: If a frame is open, the serializer bank is empty, no bank is committed and serReady is 1, then serAbort and underrunEvt are high for exactly one cycle, starting in the next cycle. The host bank is emptied at the same time.
- R8: After the last byte of a frame has been accepted, serReady held high causes no underrun.
- R9: allSent is 1 in a cycle only if, in the previous cycle, both banks were empty, no frame was open and lineIdle was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | DW | Host byte |
| cmdSend | input | 1 | Commit a full bank, frame continues |
| cmdEnd | input | 1 | Commit the bank as the end of the frame |
| poolReady | output | 1 | Host bank is free for a new block |
| serValid | output | 1 | Byte available to the serializer |
| serData | output | DW | Byte to the serializer |
| serLast | output | 1 | Current byte closes the frame |
| serReady | input | 1 | Serializer takes or requests a byte |
| serAbort | output | 1 | One-cycle abort sequence request |
| underrunEvt | output | 1 | One-cycle underrun status |
| lineIdle | input | 1 | Serializer reports the last bit has left the line |
| allSent | output | 1 | Banks empty and line idle |

## Verification
The bank-select bit and the byte counters are state that is not visible at the ports. A wrong bank select shows up on serData at the first byte after a trade, because the bytes come from the stale bank. A wrong remaining-byte count shows up either as a missing or misplaced serLast, or as an early or late underrun pulse within one cycle of the end of the block. A stuck commit flag holds poolReady low one cycle past the trade, and the exact-cycle checks of poolReady detect that.

// File: rtl/hdlc_tx_pool_pkg.sv
package hdlc_tx_pool_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;    // store host byte
    logic rdStb;    // serializer took a byte
    logic swapStb;  // banks trade roles
    logic clrHost;  // discard host bank
  } poolStrobe_t;
endpackage

// File: rtl/hdlc_tx_pool_dp.sv
module hdlc_tx_pool_dp
  import hdlc_tx_pool_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  poolStrobe_t   stb,
  input  logic [DW-1:0] wrData,
  output logic [CW-1:0] wrCount,
  output logic [DW-1:0] rdData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [2][DEPTH];
  logic          hostBank;
  logic          readBank;
  logic [CW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  assign readBank = ~hostBank;
  assign wrCount  = wrPtr;
  assign rdData   = mem[readBank][rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostBank <= 1'b0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else if (stb.swapStb) begin
      hostBank <= ~hostBank;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      if (stb.clrHost)    wrPtr <= '0;
      else if (stb.wrStb) wrPtr <= wrPtr + 1'b1;
      if (stb.rdStb)      rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[hostBank][wrPtr[PW-1:0]] <= wrData;
  end
endmodule

// File: rtl/hdlc_tx_pool_ctl.sv
module hdlc_tx_pool_ctl
  import hdlc_tx_pool_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] wrCount,
  input  logic          hostWrEn,
  input  logic          cmdSend,
  input  logic          cmdEnd,
  input  logic          serReady,
  input  logic          lineIdle,
  output poolStrobe_t   stb,
  output logic          poolReady,
  output logic          serValid,
  output logic          serLast,
  output logic          serAbort,
  output logic          underrunEvt,
  output logic          allSent
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          committed, blkEom, shEom, inFrame, abortQ, allSentQ;
  logic [CW-1:0] blkLen, shRem;
  logic          hostFull, shEmpty, underrunDet, sendOk, endOk, wrOk, rdGo, swapGo;

  assign hostFull    = (wrCount == FULL);
  assign shEmpty     = (shRem == '0);
  assign underrunDet = inFrame && shEmpty && !committed && serReady;
  assign endOk       = cmdEnd && !committed && (wrCount != '0) && !underrunDet;
  assign sendOk      = cmdSend && !cmdEnd && !committed && hostFull && !underrunDet;
  assign wrOk        = hostWrEn && !cmdSend && !cmdEnd && !committed && !hostFull && !underrunDet;
  assign swapGo      = committed && shEmpty;
  assign rdGo        = serValid && serReady;

  assign stb.wrStb   = wrOk;
  assign stb.rdStb   = rdGo;
  assign stb.swapStb = swapGo;
  assign stb.clrHost = underrunDet;

  assign poolReady   = !committed;
  assign serValid    = !shEmpty;
  assign serLast     = shEom && (shRem == CW'(1));
  assign serAbort    = abortQ;
  assign underrunEvt = abortQ;
  assign allSent     = allSentQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      committed <= 1'b0;
      blkLen    <= '0;
      blkEom    <= 1'b0;
      shRem     <= '0;
      shEom     <= 1'b0;
      inFrame   <= 1'b0;
      abortQ    <= 1'b0;
      allSentQ  <= 1'b0;
    end else begin
      if (swapGo) begin
        committed <= 1'b0;
        shRem     <= blkLen;
        shEom     <= blkEom;
      end else if (sendOk || endOk) begin
        committed <= 1'b1;
        blkLen    <= wrCount;
        blkEom    <= endOk;
      end
      if (rdGo) begin
        shRem   <= shRem - 1'b1;
        inFrame <= !serLast;
      end else if (underrunDet) begin
        inFrame <= 1'b0;
      end
      abortQ   <= underrunDet;
      allSentQ <= !committed && (wrCount == '0) && shEmpty && !inFrame && lineIdle;
    end
  end
endmodule

// File: rtl/hdlc_tx_pool.sv
module hdlc_tx_pool
  import hdlc_tx_pool_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [DW-1:0] hostWrData,
  input  logic          cmdSend,
  input  logic          cmdEnd,
  output logic          poolReady,
  output logic          serValid,
  output logic [DW-1:0] serData,
  output logic          serLast,
  input  logic          serReady,
  output logic          serAbort,
  output logic          underrunEvt,
  input  logic          lineIdle,
  output logic          allSent
);
  localparam int CW = $clog2(DEPTH + 1);

  poolStrobe_t   stb;
  logic [CW-1:0] wrCount;

  hdlc_tx_pool_dp #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostWrData),
    .wrCount(wrCount), .rdData(serData)
  );

  hdlc_tx_pool_ctl #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .hostWrEn(hostWrEn),
    .cmdSend(cmdSend), .cmdEnd(cmdEnd), .serReady(serReady), .lineIdle(lineIdle),
    .stb(stb), .poolReady(poolReady), .serValid(serValid), .serLast(serLast),
    .serAbort(serAbort), .underrunEvt(underrunEvt), .allSent(allSent)
  );
endmodule

// File: rtl/hdlc_tx_pool_chk.sv
module hdlc_tx_pool_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          poolReady,
  input logic          serValid,
  input logic [DW-1:0] serData,
  input logic          serReady,
  input logic          serAbort,
  input logic          lineIdle,
  input logic          allSent
);
  AST_SWAP_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    (!poolReady && !serValid) |=> poolReady); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (serValid && !serReady) |=> (serValid && $stable(serData))); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    serAbort |=> !serAbort); // R7
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    serAbort |-> (poolReady && !serValid)); // R7
  AST_ALLSENT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    allSent |-> $past(poolReady && !serValid && lineIdle)); // R9
endmodule

bind hdlc_tx_pool hdlc_tx_pool_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .poolReady(poolReady), .serValid(serValid),
  .serData(serData), .serReady(serReady), .serAbort(serAbort),
  .lineIdle(lineIdle), .allSent(allSent)
);

// File: tb/sim_hdlc_tx_pool.sv
module sim_hdlc_tx_pool;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int DW = 8;
  // frame table: {length[13:8], first byte[7:0]}, bytes count up from the first
  localparam logic [13:0] FRAMES [4] = '{
    {6'd1, 8'h10}, {6'd5, 8'hA0}, {6'd32, 8'h33}, {6'd3, 8'hF8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, cmdSend = 1'b0, cmdEnd = 1'b0;
  logic serReady = 1'b0, lineIdle = 1'b1;
  logic [DW-1:0] hostWrData = '0;
  logic poolReady, serValid, serLast, serAbort, underrunEvt, allSent;
  logic [DW-1:0] serData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] expQ [80];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_pool #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .cmdSend(cmdSend), .cmdEnd(cmdEnd), .poolReady(poolReady), .serValid(serValid),
    .serData(serData), .serLast(serLast), .serReady(serReady), .serAbort(serAbort),
    .underrunEvt(underrunEvt), .lineIdle(lineIdle), .allSent(allSent)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      finishRun();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeBytes(input int n, input logic [DW-1:0] seed, input int base);
    for (int i = 0; i < n; i++) begin
      hostWrEn = 1'b1; hostWrData = seed + DW'(i);
      if (base + i < 80) expQ[base + i] = seed + DW'(i);
      @(negedge clk);
    end
    hostWrEn = 1'b0;
  endtask

  task automatic issue(input logic isEnd);
    if (isEnd) cmdEnd = 1'b1; else cmdSend = 1'b1;
    @(negedge clk);
    cmdEnd = 1'b0; cmdSend = 1'b0;
  endtask

  // takes n bytes; serLast expected only at index lastIdx
  task automatic drain(input int n, input int lastIdx, input string req);
    int idx = 0;
    int guard = 0;
    serReady = 1'b1;
    while (idx < n && guard < 400) begin
      if (serValid) begin
        chk(req, "serData", serData, expQ[idx]);
        chk("R6", "serLast", serLast, idx == lastIdx);
        idx++;
      end
      guard++;
      @(negedge clk);
    end
    chk(req, "bytes drained", idx, n);
  endtask

  initial begin
    logic [DW-1:0] held;
    #(CLK_PERIOD * 3 + CLK_PERIOD / 2);
    rstN = 1'b1;
    // R1 reset state, before any edge after release
    chk("R1", "poolReady", poolReady, 1);
    chk("R1", "serValid", serValid, 0);
    chk("R1", "serAbort", serAbort, 0);
    chk("R1", "underrunEvt", underrunEvt, 0);
    chk("R1", "allSent", allSent, 0);
    @(negedge clk);
    chk("R1", "allSent after edge", allSent, 1);

    // R3 end with empty bank ignored
    issue(1'b1);
    chk("R3", "poolReady after empty end", poolReady, 1);
    // R3 continue with partial bank ignored
    writeBytes(2, 8'h21, 0);
    issue(1'b0);
    chk("R3", "poolReady after partial send", poolReady, 1);
    issue(1'b1);
    chk("R4", "poolReady after end", poolReady, 0);
    @(negedge clk);
    chk("R4", "poolReady after trade", poolReady, 1);
    drain(2, 1, "R3");

    // table of single-block frames, R5 order and R6 last flag
    for (int f = 0; f < 4; f++) begin
      writeBytes(int'(FRAMES[f][13:8]), FRAMES[f][7:0], 0);
      @(negedge clk);
      chk("R9", "allSent with host bytes", allSent, 0);
      issue(1'b1);
      drain(int'(FRAMES[f][13:8]), int'(FRAMES[f][13:8]) - 1, "R5");
    end
    @(negedge clk);
    chk("R8", "no abort after table", serAbort, 0);

    // two-block frame: full continue block then 5-byte end block
    serReady = 1'b0; lineIdle = 1'b0;
    writeBytes(DEPTH, 8'h80, 0);
    issue(1'b0);
    chk("R4", "poolReady after send", poolReady, 0);
    @(negedge clk);
    chk("R4", "poolReady after trade", poolReady, 1);
    chk("R4", "serValid after trade", serValid, 1);
    held = serData;
    @(negedge clk); @(negedge clk);
    chk("R5", "serData held while not ready", serData, held);
    writeBytes(5, 8'hC0, DEPTH);
    issue(1'b1);
    @(negedge clk);
    chk("R4", "poolReady while serializer bank busy", poolReady, 0);
    drain(DEPTH + 5, DEPTH + 4, "R5");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "no abort after final byte", serAbort, 0);
    end
    chk("R9", "allSent held low by busy line", allSent, 0);
    lineIdle = 1'b1;
    @(negedge clk);
    chk("R9", "allSent after line idle", allSent, 1);

    // underrun: full continue block, host writes 3 bytes without committing
    serReady = 1'b0;
    writeBytes(DEPTH, 8'h00, 0);
    issue(1'b0);
    @(negedge clk);
    writeBytes(3, 8'hE0, 60);
    drain(DEPTH, -1, "R7");
    chk("R7", "no abort before request", serAbort, 0);
    @(negedge clk);
    chk("R7", "serAbort", serAbort, 1);
    chk("R7", "underrunEvt", underrunEvt, 1);
    chk("R7", "poolReady at abort", poolReady, 1);
    @(negedge clk);
    chk("R7", "serAbort one cycle", serAbort, 0);
    chk("R7", "underrunEvt one cycle", underrunEvt, 0);
    // host bank must have been emptied: a 1-byte end frame gives just that byte
    writeBytes(1, 8'h77, 0);
    issue(1'b1);
    drain(1, 0, "R7");

    // R2 write beyond a full bank is ignored
    writeBytes(DEPTH, 8'h40, 0);
    writeBytes(1, 8'h99, 70);
    issue(1'b1);
    drain(DEPTH, DEPTH - 1, "R2");
    @(negedge clk);
    chk("R8", "no abort after overflow frame", serAbort, 0);

    finishRun();
  end
endmodule